// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog Timer

This peripheral supervises software with a free-running tick counter and two independent thresholds. When the counter reaches the first threshold, the block raises an interrupt (the bark) so that software gets one chance to recover. When it reaches the second threshold, the block asks the system for a reset (the bite). Software keeps the block quiet by writing a restart command often enough. The restart command clears the counter and leaves counting enabled.

Software programs the block through a simple single-cycle register bus. Each cycle carries a select, a write strobe, an address and write data, and read data comes back combinationally. There are five registers: restart, enable, status, bark threshold and bite threshold. The thresholds are given directly in clock ticks, so software computes them as the timeout in seconds multiplied by the tick rate. The normal reprogramming sequence is: disable, restart, write bark, write bite, enable.

A sticky flag records that a bite took place. Its reset comes from a separate power-on reset input, so the flag survives the system reset that the bite itself causes. After boot, software can read the flag to learn why the system restarted. A parameter selects one of two fixed register layouts.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, enable reads 0, both thresholds read 0x1FFFFFFF (all 29 bits set), and `bark_irq` and `bite_req` are 0. After a power-on reset, status reads 0.
- R2: With ALT_MAP=0 the registers are at these offsets: restart 0x04, enable 0x08, status 0x0C, bark threshold 0x10, bite threshold 0x14. With ALT_MAP=1 they are at 0x38, 0x40, 0x44, 0x4C and 0x5C. Each threshold stores and returns the low 29 bits of the written data. Restart, all unmapped offsets, and every bit above bit 0 of enable and status read as 0.
- R3: Enable bit 0 set to 1 makes the counter advance by one each clock. Set to 0, it freezes the counter at its value.
- R4: A write to restart with data bit 0 = 1 clears the counter and `bark_irq` at the write edge and leaves the enable bit unchanged. A write to restart with bit 0 = 0 has no effect.
- R5: If enable is written to 1 at edge E while the counter is 0, then `bark_irq` first reads 1 after edge E+B+1, where B is the bark threshold. It then stays 1 until a restart write or a write of 0 to enable.
- R6: Under the same conditions, `bite_req` rises after edge E+T+1, where T is the bite threshold, and stays high for exactly BITE_HOLD (16) cycles. After a bite the counter stays stopped until software writes the enable register again.
- R7: Status bit 0 becomes 1 when a bite starts. It is kept through `rst_n` and cleared only by `por_n` or by a write of 1 to status bit 0. A write of 0 to status has no effect.
- R8: Thresholds written while the block is disabled take effect when it is next enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | System reset, active low (also pulled by the bite) |
| por_n | input | 1 | Power-on reset for the bite-cause flag, active low |
| bus_sel | input | 1 | Register access select |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed register (combinational) |
| bark_irq | output | 1 | Bark interrupt, held level |
| bite_req | output | 1 | Reset request, BITE_HOLD-cycle level |

## Verification
The assertions assume the following about the inputs:
- Each bus write lasts exactly one cycle of `bus_sel` and `bus_write`.
- `rst_n` is never pulled while `bite_req` is high, so the checker's count of the reset pulse length is never cut short.
- Whenever `por_n` is asserted, `rst_n` is asserted with it.

The bench keeps within these limits in three ways:
- Its write task holds the strobes for exactly one clock edge.
- It pulses either reset only after the bite pulse has ended.
- It always asserts `rst_n` together with `por_n`.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  localparam int MAX_W = 64;

  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_RESTART,
    SLOT_ENABLE,
    SLOT_STATUS,
    SLOT_BARK,
    SLOT_BITE
  } slot_e;

  // Map a byte offset to a register slot for the selected layout.
  function automatic slot_e decode_slot(input logic [31:0] offs, input bit alt);
    slot_e s;
    s = SLOT_NONE;
    if (!alt) begin
      case (offs)
        32'h04:  s = SLOT_RESTART;
        32'h08:  s = SLOT_ENABLE;
        32'h0C:  s = SLOT_STATUS;
        32'h10:  s = SLOT_BARK;
        32'h14:  s = SLOT_BITE;
        default: s = SLOT_NONE;
      endcase
    end else begin
      case (offs)
        32'h38:  s = SLOT_RESTART;
        32'h40:  s = SLOT_ENABLE;
        32'h44:  s = SLOT_STATUS;
        32'h4C:  s = SLOT_BARK;
        32'h5C:  s = SLOT_BITE;
        default: s = SLOT_NONE;
      endcase
    end
    return s;
  endfunction

  // Threshold compare: true once the count has reached the limit.
  function automatic logic at_or_past(input logic [MAX_W-1:0] count,
                                      input logic [MAX_W-1:0] limit);
    return count >= limit;
  endfunction

endpackage

// File: rtl/wdog_cause.sv
`timescale 1ns/1ps
module wdog_cause (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  // Only the power-on reset touches this flag; set wins over clear.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_o <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int HOLD  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] bark_thr_i,
  input  logic [CNT_W-1:0] bite_thr_i,
  input  logic             restart_i,
  input  logic             disable_i,
  input  logic             en_wr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             halted_o,
  output logic             bark_o,
  output logic             bite_o,
  output logic             bite_start_o
);

  localparam int HOLD_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD - 1);
  localparam logic [CNT_W-1:0]  CNT_TOP   = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              halted_q;
  logic              bark_q;
  logic              bite_q;
  logic              running;
  logic              bark_hit;
  logic              bite_hit;

  assign running  = en_i && !halted_q;
  assign bark_hit = running && at_or_past(MAX_W'(cnt_q), MAX_W'(bark_thr_i));
  assign bite_hit = running && !bite_q && at_or_past(MAX_W'(cnt_q), MAX_W'(bite_thr_i));

  // Tick counter: restart wins, then saturating increment while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (running && cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Bark level: set on reaching the threshold, cleared by restart or disable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bark_q <= 1'b0;
    end else if (restart_i || disable_i) begin
      bark_q <= 1'b0;
    end else if (bark_hit) begin
      bark_q <= 1'b1;
    end
  end

  // Bite pulse of HOLD cycles, then counting stays halted until an enable write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bite_q   <= 1'b0;
      hold_q   <= '0;
      halted_q <= 1'b0;
    end else begin
      if (bite_hit) begin
        bite_q <= 1'b1;
        hold_q <= HOLD_LOAD;
      end else if (bite_q) begin
        if (hold_q == '0) begin
          bite_q <= 1'b0;
        end else begin
          hold_q <= hold_q - 1'b1;
        end
      end
      if (bite_hit) begin
        halted_q <= 1'b1;
      end else if (en_wr_i) begin
        halted_q <= 1'b0;
      end
    end
  end

  assign cnt_o        = cnt_q;
  assign halted_o     = halted_q;
  assign bark_o       = bark_q;
  assign bite_o       = bite_q;
  assign bite_start_o = bite_hit;

endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 29,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cause_i,
  output logic              en_o,
  output logic [CNT_W-1:0]  bark_thr_o,
  output logic [CNT_W-1:0]  bite_thr_o,
  output logic              restart_o,
  output logic              disable_o,
  output logic              en_wr_o,
  output logic              cause_clr_o,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int NTHR = 2;
  localparam slot_e THR_SLOT [NTHR] = '{SLOT_BARK, SLOT_BITE};

  slot_e            slot;
  logic             wr_acc;
  logic             bit0;
  logic             en_q;
  logic [CNT_W-1:0] thr_q [NTHR];

  assign slot   = decode_slot(32'(bus_addr), ALT_MAP);
  assign wr_acc = bus_sel && bus_write;
  assign bit0   = bus_wdata[0];

  assign restart_o   = wr_acc && (slot == SLOT_RESTART) && bit0;
  assign en_wr_o     = wr_acc && (slot == SLOT_ENABLE);
  assign disable_o   = en_wr_o && !bit0;
  assign cause_clr_o = wr_acc && (slot == SLOT_STATUS) && bit0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_wr_o) begin
      en_q <= bit0;
    end
  end

  // Both thresholds share one register structure.
  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q[g] <= '1;
      end else if (wr_acc && slot == THR_SLOT[g]) begin
        thr_q[g] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  assign en_o       = en_q;
  assign bark_thr_o = thr_q[0];
  assign bite_thr_o = thr_q[1];

  always_comb begin
    bus_rdata = '0;
    case (slot)
      SLOT_ENABLE: bus_rdata[0] = en_q;
      SLOT_STATUS: bus_rdata[0] = cause_i;
      SLOT_BARK:   bus_rdata    = DATA_W'(thr_q[0]);
      SLOT_BITE:   bus_rdata    = DATA_W'(thr_q[1]);
      default:     bus_rdata    = '0;
    endcase
  end

endmodule

// File: rtl/wdog_two_stage.sv
`timescale 1ns/1ps
module wdog_two_stage #(
  parameter int CNT_W     = 29,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BITE_HOLD = 16,
  parameter bit ALT_MAP   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bark_irq,
  output logic              bite_req
);

  logic             en_q;
  logic [CNT_W-1:0] bark_thr;
  logic [CNT_W-1:0] bite_thr;
  logic             restart_pulse;
  logic             dis_pulse;
  logic             en_wr_pulse;
  logic             cause_clr;
  logic             cause_q;
  logic [CNT_W-1:0] cnt_q;
  logic             halted_q;
  logic             bite_start;

  wdog_regs #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ALT_MAP(ALT_MAP)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cause_i    (cause_q),
    .en_o       (en_q),
    .bark_thr_o (bark_thr),
    .bite_thr_o (bite_thr),
    .restart_o  (restart_pulse),
    .disable_o  (dis_pulse),
    .en_wr_o    (en_wr_pulse),
    .cause_clr_o(cause_clr),
    .bus_rdata  (bus_rdata)
  );

  wdog_core #(
    .CNT_W(CNT_W),
    .HOLD (BITE_HOLD)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_q),
    .bark_thr_i  (bark_thr),
    .bite_thr_i  (bite_thr),
    .restart_i   (restart_pulse),
    .disable_i   (dis_pulse),
    .en_wr_i     (en_wr_pulse),
    .cnt_o       (cnt_q),
    .halted_o    (halted_q),
    .bark_o      (bark_irq),
    .bite_o      (bite_req),
    .bite_start_o(bite_start)
  );

  wdog_cause u_cause (
    .clk   (clk),
    .por_n (por_n),
    .set_i (bite_start),
    .clr_i (cause_clr),
    .flag_o(cause_q)
  );

endmodule

// File: rtl/wdog_two_stage_chk.sv
`timescale 1ns/1ps
module wdog_two_stage_chk #(
  parameter int CNT_W = 29,
  parameter int HOLD  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             en,
  input logic             halted,
  input logic [CNT_W-1:0] cnt,
  input logic             restart_pulse,
  input logic             dis_pulse,
  input logic             bite_start,
  input logic             bark_irq,
  input logic             bite_req,
  input logic             cause_flag
);

  localparam int LEN_W = $clog2(HOLD + 2);

  logic [LEN_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
    end else if (bite_req) begin
      hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
    end
  end

  // R3: a disabled block keeps its count unless restarted
  assert_frozen_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart_pulse) |=> $stable(cnt));

  // R4: a restart command zeroes the count and drops the bark
  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> (cnt == '0 && !bark_irq));

  // R5: the bark holds until restart or disable
  assert_bark_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bark_irq && !restart_pulse && !dis_pulse) |=> bark_irq);

  // R6: the reset request lasts exactly HOLD cycles
  assert_bite_len_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bite_req |-> (hi_len < LEN_W'(HOLD)));

  assert_bite_len_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bite_req) |-> (hi_len == LEN_W'(HOLD)));

  // R6: a bite starts only while counting is live
  assert_bite_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bite_req) |-> $past(en && !halted));

  // R7: a bite always leaves the cause flag set
  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!por_n)
    bite_start |=> cause_flag);

endmodule

bind wdog_two_stage wdog_two_stage_chk #(
  .CNT_W(CNT_W),
  .HOLD (BITE_HOLD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .por_n        (por_n),
  .en           (en_q),
  .halted       (halted_q),
  .cnt          (cnt_q),
  .restart_pulse(restart_pulse),
  .dis_pulse    (dis_pulse),
  .bite_start   (bite_start),
  .bark_irq     (bark_irq),
  .bite_req     (bite_req),
  .cause_flag   (cause_q)
);

// File: tb/wdog_two_stage_bench.sv
`timescale 1ns/1ps
module wdog_two_stage_bench;

  localparam logic [31:0] THR_RESET = 32'h1FFF_FFFF;
  localparam int NVEC = 8;
  // {offset, write data, expected read-back}
  localparam logic [71:0] VEC [0:NVEC-1] = '{
    {8'h10, 32'h1234_5678, 32'h1234_5678},
    {8'h14, 32'hFFFF_FFFF, 32'h1FFF_FFFF},
    {8'h08, 32'h0000_0002, 32'h0000_0000},
    {8'h04, 32'h0000_0001, 32'h0000_0000},
    {8'h20, 32'h0000_ABCD, 32'h0000_0000},
    {8'h00, 32'h0000_0005, 32'h0000_0000},
    {8'h10, 32'h0000_0000, 32'h0000_0000},
    {8'h0C, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        sel_m = 1'b0;
  logic        sel_a = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_m, rd_a;
  logic        bark_m, bite_m, bark_a, bite_a;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_two_stage u_wdog_two_stage (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .bus_sel(sel_m), .bus_write(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_m), .bark_irq(bark_m), .bite_req(bite_m)
  );

  wdog_two_stage #(.ALT_MAP(1'b1)) u_wdog_two_stage_alt (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .bus_sel(sel_a), .bus_write(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_a), .bark_irq(bark_a), .bite_req(bite_a)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input bit alt, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_m = !alt; sel_a = alt; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel_m = 1'b0; sel_a = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input bit alt, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel_m = !alt; sel_a = alt; wr = 1'b0; addr = a;
    #2;
    d = alt ? rd_a : rd_m;
    sel_m = 1'b0; sel_a = 1'b0;
  endtask

  // Cycles from t0 until the selected output is first seen high.
  task automatic wait_high(input bit which_bite, input int t0, input int limit, output int delta);
    delta = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((which_bite ? bite_m : bark_m) == 1'b1) begin
        delta = cyc - t0;
        break;
      end
    end
  endtask

  task automatic program_run(input int b, input int t, output int t0);
    wr_reg(0, 8'h08, 32'h0);
    wr_reg(0, 8'h04, 32'h1);
    wr_reg(0, 8'h10, 32'(b));
    wr_reg(0, 8'h14, 32'(t));
    wr_reg(0, 8'h08, 32'h1);
    t0 = cyc;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1: actual=watchdog-timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    int t0, t1, dd, d, hi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;

    // R1: reset state
    check("R1 bark_irq", 32'(bark_m), 32'h0);
    check("R1 bite_req", 32'(bite_m), 32'h0);
    rd_reg(0, 8'h08, r); check("R1 enable", r, 32'h0);
    rd_reg(0, 8'h10, r); check("R1 bark thr", r, THR_RESET);
    rd_reg(0, 8'h14, r); check("R1 bite thr", r, THR_RESET);
    rd_reg(0, 8'h0C, r); check("R1 status", r, 32'h0);

    // R2: register map walk (default layout)
    for (int i = 0; i < NVEC; i++) begin
      wr_reg(0, VEC[i][71:64], VEC[i][63:32]);
      rd_reg(0, VEC[i][71:64], r);
      check("R2 map", r, VEC[i][31:0]);
    end

    // R2: alternate layout
    wr_reg(1, 8'h4C, 32'h55);
    rd_reg(1, 8'h4C, r); check("R2 alt bark", r, 32'h55);
    rd_reg(1, 8'h10, r); check("R2 alt old offset", r, 32'h0);
    rd_reg(1, 8'h5C, r); check("R2 alt bite", r, THR_RESET);
    rd_reg(0, 8'h4C, r); check("R2 main alt offset", r, 32'h0);

    // R5: bark timing with threshold 0
    program_run(0, 1000, t0);
    wait_high(0, t0, 50, d); check("R5 bark at B+1 (B=0)", 32'(d), 32'd1);

    // R3: disable freezes the count
    program_run(20, 1000, t0);
    repeat (6) @(negedge clk);
    wr_reg(0, 8'h08, 32'h0);
    dd = cyc - t0;
    check("R3 bark low while early", 32'(bark_m), 32'h0);
    repeat (15) @(negedge clk);
    check("R3 no bark while disabled", 32'(bark_m), 32'h0);
    wr_reg(0, 8'h08, 32'h1);
    t1 = cyc;
    wait_high(0, t1, 100, d); check("R3 resumed count", 32'(d), 32'(20 - dd + 1));

    // R5: bark stays up, then disable drops it
    repeat (10) @(negedge clk);
    check("R5 bark held", 32'(bark_m), 32'h1);
    wr_reg(0, 8'h08, 32'h0);
    check("R5 disable clears bark", 32'(bark_m), 32'h0);

    // R4: restart with bit0=0 is ignored, bit0=1 restarts
    program_run(20, 1000, t0);
    repeat (8) @(negedge clk);
    wr_reg(0, 8'h04, 32'h2);
    wait_high(0, t0, 100, d); check("R4 restart bit0=0 ignored", 32'(d), 32'd21);
    wr_reg(0, 8'h04, 32'h1);
    t1 = cyc;
    check("R4 restart clears bark", 32'(bark_m), 32'h0);
    rd_reg(0, 8'h08, r); check("R4 enable kept", r, 32'h1);
    wait_high(0, t1, 100, d); check("R4 count restarted", 32'(d), 32'd21);

    // R8: thresholds changed while disabled
    wr_reg(0, 8'h08, 32'h0);
    wr_reg(0, 8'h10, 32'd30);
    wr_reg(0, 8'h10, 32'd8);
    wr_reg(0, 8'h04, 32'h1);
    wr_reg(0, 8'h08, 32'h1);
    t0 = cyc;
    wait_high(0, t0, 100, d); check("R8 new bark threshold", 32'(d), 32'd9);

    // R6: bite timing and pulse width
    program_run(10, 25, t0);
    wait_high(1, t0, 100, d); check("R6 bite at T+1", 32'(d), 32'd26);
    check("R5 bark before bite", 32'(bark_m), 32'h1);
    hi = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!bite_m) break;
      hi++;
    end
    check("R6 bite width", 32'(hi), 32'd16);
    rd_reg(0, 8'h0C, r); check("R7 status after bite", r, 32'h1);

    // R6: halted after bite until enable written
    wr_reg(0, 8'h04, 32'h1);
    repeat (20) @(negedge clk);
    check("R6 halted after bite", 32'(bark_m), 32'h0);
    wr_reg(0, 8'h08, 32'h1);
    t1 = cyc;
    wait_high(0, t1, 100, d); check("R6 rearm by enable write", 32'(d), 32'd11);
    wr_reg(0, 8'h08, 32'h0);

    // R7: flag survives system reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd_reg(0, 8'h0C, r); check("R7 status survives rst_n", r, 32'h1);
    rd_reg(0, 8'h08, r); check("R1 enable after rst_n", r, 32'h0);
    rd_reg(0, 8'h10, r); check("R1 bark thr after rst_n", r, THR_RESET);
    wr_reg(0, 8'h0C, 32'h0);
    rd_reg(0, 8'h0C, r); check("R7 write 0 ignored", r, 32'h1);
    wr_reg(0, 8'h0C, 32'h1);
    rd_reg(0, 8'h0C, r); check("R7 write 1 clears", r, 32'h0);

    // R7: power-on reset clears the flag
    program_run(2, 4, t0);
    repeat (30) @(negedge clk);
    wr_reg(0, 8'h08, 32'h0);
    rd_reg(0, 8'h0C, r); check("R7 second bite sets", r, 32'h1);
    @(negedge clk); rst_n = 1'b0; por_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1; por_n = 1'b1;
    rd_reg(0, 8'h0C, r); check("R7 por clears", r, 32'h0);

    done = 1'b1;
    finish_run();
  end

endmodule